// File: doc/BRIEF.md
# Reduced 2x2 Inverse DCT

This block turns one 8x8 block of signed quantized transform coefficients into a 2x2 block of unsigned 8-bit pixels. It is the small-output path of an image decoder. Each coefficient is first dequantized against its own table entry. A column pass and then a row pass use fixed-point constants, and the result is descaled, centred on 128 and clamped. The arithmetic is bit-exact to a 13-bit fixed-point reduced-size inverse transform.

A producer streams 64 words in row-major order over a valid/ready handshake. Each word carries one coefficient and its quantization value. The column pass is folded into the load: each word does one multiply-accumulate into the accumulator of its column. After the last word, one cycle narrows the column results into a two-row intermediate store. The row pass then spends eight cycles on the same multiplier. The four pixels leave over a second valid/ready stream. No new block is taken until the fourth pixel has been accepted.

Top module: `rdct2x2`

## Requirements
- R1: The dequantized value of a coefficient is the low 16 bits of the signed product of coefficient and quantization value, read as signed. For example 256 with quantization 257 behaves like 256.
- R2: Coefficients in rows 2, 4 and 6 have no effect on the pixels. Neither do those in columns 2, 4 and 6, for any row.
- R3: For each line, the odd term is 29692·x1 − 10426·x3 + 6967·x5 − 5906·x7, wrapped to 32 bits. The even term is x0 shifted left by 15.
- R4: The column pass adds the rounding constant 4096 to (even+odd) and to (even−odd), shifts each right by 13 and keeps the low 16 bits. These form intermediate rows 0 and 1.
- R5: The row pass takes the top 16 bits of the 32-bit (even±odd), adds 8, shifts right arithmetically by 4 and adds 128.
- R6: Pixel values clamp to 0 when below 0 and to 255 when above 255.
- R7: Pixels leave in four beats in this order: (row 0, col 0), (row 0, col 1), (row 1, col 0), (row 1, col 1). Column 0 comes from the sum and column 1 from the difference. Output row n comes from intermediate row n.
- R8: inReady is low from the acceptance of the 64th word until the 4th pixel is accepted. outValid is never high while inReady is high. A stalled pixel holds its value until accepted.
- R9: After reset, inReady is high and outValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input word is valid |
| inReady | output | 1 | Block accepts an input word |
| inCoef | input | 16 | Signed quantized coefficient |
| inQuant | input | 16 | Signed quantization value |
| outValid | output | 1 | Output pixel is valid |
| outReady | input | 1 | Consumer accepts the pixel |
| outPixel | output | 8 | Unsigned pixel value |

## Verification
The hardest case to reach from the ports is a block where only the 16-bit wraps decide the result. In such a block, the dequantized product or the narrowed column result overflows but still lands in the visible 0..255 range. Random blocks almost always saturate and so hide the wrap. Directed single-coefficient vectors therefore place one chosen value at a chosen position, with hand-derived pixels. One of these is a product that wraps back to a small value. A reference model then covers random blocks at both small and full-range magnitudes, and a paired run compares a block against the same block with its ignored rows and columns cleared.

// File: rtl/rdct2_pkg.sv
package rdct2_pkg;
  localparam int BLK_N  = 64;                 // words per block
  localparam int IDX_W  = $clog2(BLK_N);
  localparam int USED_N = 5;                  // used lines: 0,1,3,5,7
  localparam int MAC_N  = 8;                  // row-pass MAC cycles
  localparam int MAC_W  = $clog2(MAC_N);
  localparam int PIX_N  = 4;
  localparam int OUT_W  = $clog2(PIX_N);
  localparam int PASS_B = 2;

  typedef enum logic [1:0] {ST_LOAD, ST_FIN, ST_MAC, ST_EMIT} stT;

  typedef struct packed {
    logic             loadEn;
    logic [IDX_W-1:0] loadIdx;
    logic             finEn;
    logic             macEn;
    logic             macRow;
    logic [1:0]       macTap;
    logic [OUT_W-1:0] outIdx;
  } ctlT;

  // Odd-term weight for tap 0..3 (inputs x1, x3, x5, x7)
  function automatic logic signed [15:0] tapConst(input logic [1:0] t);
    case (t)
      2'd0:    return 16'sd29692;
      2'd1:    return -16'sd10426;
      2'd2:    return 16'sd6967;
      default: return -16'sd5906;
    endcase
  endfunction
endpackage

// File: rtl/rdct2_ctrl.sv
module rdct2_ctrl
  import rdct2_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic outReady,
  output logic inReady,
  output logic outValid,
  output ctlT  ctl
);
  stT               state;
  logic [IDX_W-1:0] loadCnt;
  logic [MAC_W-1:0] macCnt;
  logic [OUT_W-1:0] outCnt;
  logic             inFire;

  assign inReady  = (state == ST_LOAD);
  assign outValid = (state == ST_EMIT);
  assign inFire   = inValid && inReady;

  always_comb begin
    ctl         = '0;
    ctl.loadEn  = inFire;
    ctl.loadIdx = loadCnt;
    ctl.finEn   = (state == ST_FIN);
    ctl.macEn   = (state == ST_MAC);
    ctl.macRow  = macCnt[MAC_W-1];
    ctl.macTap  = macCnt[1:0];
    ctl.outIdx  = outCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_LOAD;
      loadCnt <= '0;
      macCnt  <= '0;
      outCnt  <= '0;
    end else begin
      case (state)
        ST_LOAD: if (inFire) begin
          loadCnt <= loadCnt + 1'b1;
          if (loadCnt == IDX_W'(BLK_N - 1)) state <= ST_FIN;
        end
        ST_FIN: begin
          macCnt <= '0;
          state  <= ST_MAC;
        end
        ST_MAC: begin
          macCnt <= macCnt + 1'b1;
          if (macCnt == MAC_W'(MAC_N - 1)) state <= ST_EMIT;
        end
        default: if (outReady) begin
          outCnt <= outCnt + 1'b1;
          if (outCnt == OUT_W'(PIX_N - 1)) state <= ST_LOAD;
        end
      endcase
    end
  end
endmodule

// File: rtl/rdct2_dp.sv
module rdct2_dp
  import rdct2_pkg::*;
#(
  parameter int CW = 16,   // coefficient / intermediate width
  parameter int AW = 32,   // accumulator width
  parameter int PW = 8,    // pixel width
  parameter int CB = 13    // fixed-point fraction bits of constants
)(
  input  logic          clk,
  input  ctlT           ctl,
  input  logic [CW-1:0] inCoef,
  input  logic [CW-1:0] inQuant,
  output logic [PW-1:0] outPixel
);
  localparam int EVSH   = CB + 2;
  localparam int RND1   = 1 << (CB - 1);
  localparam int HI_SH  = AW - CW;
  localparam int P2SH   = CB + PASS_B + 3 + 2 - CW;
  localparam int RND2   = 1 << (P2SH - 1);
  localparam int CENTER = 1 << (PW - 1);
  localparam logic signed [CW+1:0] MAXV = (CW+2)'((1 << PW) - 1);

  logic signed [CW-1:0] deq;
  logic [2:0]           loadRow;
  logic [1:0]           tapSel;
  logic signed [CW-1:0] mulA, coefK, midSel;
  logic signed [AW-1:0] prod;
  logic [1:0][USED_N-1:0][CW-1:0] midFlat;
  logic signed [AW-1:0] odd2 [2];

  assign deq     = CW'($signed(inCoef) * $signed(inQuant));
  assign loadRow = ctl.loadIdx[IDX_W-1 -: 3];
  assign tapSel  = ctl.macEn ? ctl.macTap : loadRow[2:1];
  assign coefK   = tapConst(tapSel);
  assign midSel  = $signed(midFlat[ctl.macRow][{1'b0, ctl.macTap} + 3'd1]);
  assign mulA    = ctl.macEn ? midSel : deq;
  assign prod    = AW'(mulA) * AW'(coefK);

  // Column pass: one accumulator pair per used column, filled during load
  for (genvar s = 0; s < USED_N; s++) begin : g_slot
    localparam logic [2:0] COL = (s == 0) ? 3'd0 : 3'(2 * s - 1);
    logic signed [AW-1:0] evenQ, oddQ;
    logic hit;
    assign hit = ctl.loadEn && (ctl.loadIdx[2:0] == COL);

    always_ff @(posedge clk) begin
      if (hit) begin
        if (loadRow == 3'd0)   evenQ <= AW'(deq) <<< EVSH;
        else if (loadRow[0])   oddQ  <= (loadRow == 3'd1) ? prod : oddQ + prod;
      end
    end

    for (genvar r = 0; r < 2; r++) begin : g_row
      logic signed [AW-1:0] sumW;
      logic signed [AW:0]   ext;
      logic [CW-1:0]        midQ;
      assign sumW = (r == 0) ? evenQ + oddQ : evenQ - oddQ;
      assign ext  = {sumW[AW-1], sumW} + (AW+1)'(RND1);
      always_ff @(posedge clk) begin
        if (ctl.finEn) midQ <= CW'(ext >>> CB);
      end
      assign midFlat[r][s] = midQ;
    end
  end

  // Row pass: four MAC steps per intermediate row on the shared multiplier
  always_ff @(posedge clk) begin
    if (ctl.macEn)
      odd2[ctl.macRow] <= (ctl.macTap == 2'd0) ? prod : odd2[ctl.macRow] + prod;
  end

  // Output stage: even/odd combine, high half, rounding shift, centre, clamp
  logic signed [AW-1:0] ev2, sum2;
  logic signed [CW-1:0] hi;
  logic signed [CW:0]   rndSum, rndSh;
  logic signed [CW+1:0] val;

  always_comb begin
    ev2    = AW'($signed(midFlat[ctl.outIdx[1]][0])) <<< EVSH;
    sum2   = ctl.outIdx[0] ? ev2 - odd2[ctl.outIdx[1]] : ev2 + odd2[ctl.outIdx[1]];
    hi     = CW'(sum2 >>> HI_SH);
    rndSum = {hi[CW-1], hi} + (CW+1)'(RND2);
    rndSh  = rndSum >>> P2SH;
    val    = {rndSh[CW], rndSh} + (CW+2)'(CENTER);
    if (val < 0)         outPixel = '0;
    else if (val > MAXV) outPixel = '1;
    else                 outPixel = val[PW-1:0];
  end
endmodule

// File: rtl/rdct2x2.sv
module rdct2x2
  import rdct2_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 32,
  parameter int PW = 8,
  parameter int CB = 13
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output logic          inReady,
  input  logic [CW-1:0] inCoef,
  input  logic [CW-1:0] inQuant,
  output logic          outValid,
  input  logic          outReady,
  output logic [PW-1:0] outPixel
);
  ctlT ctl;

  rdct2_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .ctl(ctl)
  );

  rdct2_dp #(.CW(CW), .AW(AW), .PW(PW), .CB(CB)) u_dp (
    .clk(clk), .ctl(ctl), .inCoef(inCoef), .inQuant(inQuant), .outPixel(outPixel)
  );
endmodule

// File: rtl/rdct2x2_chk.sv
module rdct2x2_chk #(
  parameter int PW = 8
)(
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic          inReady,
  input logic          outValid,
  input logic          outReady,
  input logic [PW-1:0] outPixel
);
  logic [5:0] inCnt;
  logic [1:0] outCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCnt  <= '0;
      outCnt <= '0;
    end else begin
      if (inValid && inReady)   inCnt  <= inCnt + 1'b1;
      if (outValid && outReady) outCnt <= outCnt + 1'b1;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outPixel)); // R8
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid)); // R8
  AST_FULL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inCnt == 6'd0); // R8
  AST_BLOCK_END: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outCnt == 2'd3 |=> inReady && !outValid); // R7
  AST_FOUR_BEATS: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> outCnt == 2'd0); // R7
endmodule

bind rdct2x2 rdct2x2_chk #(.PW(PW)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outPixel(outPixel)
);

// File: tb/sim_rdct2x2.sv
module sim_rdct2x2;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic outReady = 1'b0;
  logic [15:0] inCoef = '0;
  logic [15:0] inQuant = '0;
  logic inReady, outValid;
  logic [7:0] outPixel;

  int nChk = 0;
  int nFail = 0;
  int blkC [64];
  int blkQ [64];
  int expP [4];
  int gotP [4];
  int keepP [4];
  int unsigned lcg = 32'h1234_5678;

  always #4 clk = ~clk;

  rdct2x2 u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inCoef(inCoef), .inQuant(inQuant), .outValid(outValid),
    .outReady(outReady), .outPixel(outPixel)
  );

  typedef struct packed {
    logic [5:0]  idx;
    logic [15:0] coef;
    logic [15:0] q;
    logic [7:0]  p0, p1, p2, p3;
  } vecT;

  localparam int NV = 13;
  localparam vecT VEC [NV] = '{
    '{6'd0,  16'h0000, 16'd1,   8'd128, 8'd128, 8'd128, 8'd128}, // R5 zero block
    '{6'd0,  16'h0064, 16'd1,   8'd141, 8'd141, 8'd141, 8'd141}, // R5
    '{6'd0,  16'hFF9C, 16'd1,   8'd116, 8'd116, 8'd116, 8'd116}, // R5 negative
    '{6'd0,  16'h03E8, 16'd1,   8'd253, 8'd253, 8'd253, 8'd253}, // R5
    '{6'd0,  16'h044C, 16'd1,   8'd255, 8'd255, 8'd255, 8'd255}, // R6 upper clamp
    '{6'd0,  16'hFBB4, 16'd1,   8'd0,   8'd0,   8'd0,   8'd0  }, // R6 lower clamp
    '{6'd0,  16'h0100, 16'd257, 8'd160, 8'd160, 8'd160, 8'd160}, // R1 product wraps
    '{6'd1,  16'h0064, 16'd1,   8'd139, 8'd117, 8'd139, 8'd117}, // R3 x1, R7 column order
    '{6'd8,  16'h0064, 16'd1,   8'd139, 8'd139, 8'd117, 8'd117}, // R3, R4, R7 row order
    '{6'd7,  16'h0064, 16'd1,   8'd126, 8'd130, 8'd126, 8'd130}, // R3 x7 weight sign
    '{6'd2,  16'h1388, 16'd1,   8'd128, 8'd128, 8'd128, 8'd128}, // R2 column 2
    '{6'd16, 16'h1388, 16'd1,   8'd128, 8'd128, 8'd128, 8'd128}, // R2 row 2
    '{6'd48, 16'h1388, 16'd1,   8'd128, 8'd128, 8'd128, 8'd128}  // R2 row 6
  };

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd16(input int lim);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'(lcg[30:15]) % lim;
  endfunction

  // Reference model written from the requirements
  task automatic model();
    int dq [64];
    int mid [2][8];
    int e, o, s, h, v;
    logic signed [31:0] p;
    longint t;
    for (int i = 0; i < 64; i++) begin
      p = blkC[i] * blkQ[i];
      dq[i] = int'($signed(p[15:0]));
    end
    for (int c = 0; c < 8; c++) begin
      e = dq[c] * 32768;
      o = 29692 * dq[8+c] - 10426 * dq[24+c] + 6967 * dq[40+c] - 5906 * dq[56+c];
      for (int r = 0; r < 2; r++) begin
        s = (r == 0) ? e + o : e - o;
        t = (longint'(s) + 4096) >>> 13;
        mid[r][c] = int'($signed(t[15:0]));
      end
    end
    for (int r = 0; r < 2; r++) begin
      e = mid[r][0] * 32768;
      o = 29692 * mid[r][1] - 10426 * mid[r][3] + 6967 * mid[r][5] - 5906 * mid[r][7];
      for (int c = 0; c < 2; c++) begin
        s = (c == 0) ? e + o : e - o;
        h = s >>> 16;
        v = ((h + 8) >>> 4) + 128;
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        expP[r*2+c] = v;
      end
    end
  endtask

  task automatic sendBlock();
    int i;
    i = 0;
    while (i < 64) begin
      inValid = 1'b1;
      inCoef  = blkC[i][15:0];
      inQuant = blkQ[i][15:0];
      if (inReady) i++;
      @(negedge clk);
    end
    inValid = 1'b0;
    check("R8 busy after load", int'(inReady), 0);
  endtask

  task automatic recvBlock(input bit stall);
    int k;
    int cyc;
    k = 0;
    cyc = 0;
    while (k < 4) begin
      outReady = stall ? cyc[0] : 1'b1;
      if (outValid && k == 0) check("R8 no input while emitting", int'(inReady), 0);
      if (outValid && outReady) begin
        gotP[k] = int'(outPixel);
        k++;
      end
      @(negedge clk);
      cyc++;
    end
    outReady = 1'b0;
  endtask

  task automatic clearBlock();
    for (int i = 0; i < 64; i++) begin
      blkC[i] = 0;
      blkQ[i] = 1;
    end
  endtask

  task automatic randBlock(input bit big);
    for (int i = 0; i < 64; i++) begin
      if (big) begin
        blkC[i] = rnd16(65536) - 32768;
        blkQ[i] = rnd16(65536) - 32768;
      end else begin
        blkC[i] = rnd16(256) - 128;
        blkQ[i] = rnd16(8) + 1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 inReady after reset", int'(inReady), 1);
    check("R9 outValid after reset", int'(outValid), 0);

    // Directed single-coefficient vectors with hand-derived pixels
    for (int v = 0; v < NV; v++) begin
      clearBlock();
      blkC[VEC[v].idx] = int'($signed(VEC[v].coef));
      blkQ[VEC[v].idx] = int'($signed(VEC[v].q));
      sendBlock();
      recvBlock(v[0]);
      check("R5 vector pixel0", gotP[0], int'(VEC[v].p0));
      check("R7 vector pixel1", gotP[1], int'(VEC[v].p1));
      check("R7 vector pixel2", gotP[2], int'(VEC[v].p2));
      check("R5 vector pixel3", gotP[3], int'(VEC[v].p3));
    end

    // Random blocks against the reference model, small and full range
    for (int b = 0; b < 8; b++) begin
      randBlock(b[0]);
      model();
      sendBlock();
      recvBlock(b[1]);
      for (int k = 0; k < 4; k++) check(b[0] ? "R6 random full range" : "R4 random small", gotP[k], expP[k]);
    end

    // R2: a block compared with itself after clearing ignored rows and columns
    randBlock(1'b0);
    sendBlock();
    recvBlock(1'b0);
    for (int k = 0; k < 4; k++) keepP[k] = gotP[k];
    for (int i = 0; i < 64; i++) begin
      if ((i / 8) inside {2, 4, 6} || (i % 8) inside {2, 4, 6}) blkC[i] = 0;
    end
    sendBlock();
    recvBlock(1'b1);
    for (int k = 0; k < 4; k++) check("R2 ignored positions", gotP[k], keepP[k]);

    // Reset while emitting returns to idle
    clearBlock();
    blkC[0] = 100;
    sendBlock();
    repeat (12) @(negedge clk);
    check("R8 pixel waiting", int'(outValid), 1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 inReady after mid reset", int'(inReady), 1);
    check("R9 outValid after mid reset", int'(outValid), 0);

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule